// File: doc/BRIEF.md
# Timing Source Mode Controller

This block runs the operating-mode state machine of a network synchronization clock source. It picks one of three modes. In free-run the output frequency comes from the local crystal alone. In locked the source tracks the active reference, which is one of eight inputs. In holdover it replays a stored frequency from the time the loop was last locked. It also honours a master/slave strap. In the slave role the source follows the master's synchronization clock and never drops into holdover by its own decision.

While the loop is locked to a valid reference, the block keeps a running average of the loop's control word. It takes one sample per update period and counts consecutive qualified samples. Once that count reaches a threshold, a holdover-available flag rises, and only then may a lost reference lead to holdover instead of free-run. The block outputs a frequency word that is a fixed nominal value in free-run, the live control word in locked, and the frozen average in holdover. The phase detector, the loop filter and the oscillator sit outside this block.

Top module: `tsrc_mode_ctrl`

## Requirements
- R1: After synchronous reset, mode_o is free-run, hold_avail_o is 0 and freq_word_o equals the parameter FREE_WORD. The mode codes are 0 = free-run, 1 = locked and 2 = holdover.
- R2: From free-run, the mode becomes locked one clock after ref_valid_i and pll_lock_i are both 1. If either one is 0, the mode stays free-run.
- R3: freq_word_o equals FREE_WORD in free-run and follows ctrl_word_i combinationally in locked.
- R4: hold_avail_o rises once QUAL_N consecutive qualified updates have occurred. An update is qualified when it falls in locked mode with ref_valid_i and pll_lock_i both high, and updates occur once per UPD_PERIOD clocks. An update in locked mode with pll_lock_i low clears the count and drops hold_avail_o.
- R5: In the master role, if the mode is locked, ref_valid_i is 0 and hold_avail_o is 1, the next mode is holdover, and freq_word_o then shows the stored average.
- R6: In the master role, if the mode is locked, ref_valid_i is 0 and hold_avail_o is 0, the next mode is free-run.
- R7: Holdover returns to locked one clock after ref_valid_i and pll_lock_i are both 1. Otherwise the mode stays in holdover.
- R8: While slave_i is 1, the next mode is always locked, whatever the state of the reference, so holdover is never entered.
- R9: lol_o equals the inverse of pll_lock_i as registered one clock earlier.
- R10: The first qualified update after the count is cleared loads the control word directly. Each later qualified update moves the average by (ctrl_word_i - average) arithmetically shifted right by AVG_SHIFT. Outside qualified updates the average does not change, so the word stays constant throughout holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_i | input | 1 | Role strap, 1 = slave |
| ref_valid_i | input | 1 | Active reference is valid |
| pll_lock_i | input | 1 | Loop reports lock |
| ctrl_word_i | input | W | Loop control word |
| mode_o | output | 2 | Current mode code |
| lol_o | output | 1 | Loss-of-lock flag |
| hold_avail_o | output | 1 | History is good enough for holdover |
| freq_word_o | output | W | Frequency word to the oscillator |

## Verification
The bench builds the block with UPD_PERIOD = 4, QUAL_N = 16, AVG_SHIFT = 2 and W = 16. With a short update period, the threshold of sixteen qualified updates, the clearing of the count by a lock drop and the convergence of the average toward a new control word all fit into a few hundred clocks. Because QUAL_N keeps its full value, the bench can check both sides of the holdover-available threshold against windows sized in whole update periods. A sample of the bench's choosing therefore never has to line up with an internal tick.

// File: rtl/tsrc_pkg.sv
package tsrc_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_LOCK = 2'd1,
        MODE_HOLD = 2'd2
    } tsrc_mode_t;

    typedef struct packed {
        logic slave;
        logic ref_ok;
        logic locked;
    } tsrc_in_t;

    // next operating mode from current mode, line status and history flag
    function automatic tsrc_mode_t next_mode(input tsrc_mode_t cur,
                                             input tsrc_in_t  st,
                                             input logic      hist_ok);
        tsrc_mode_t n;
        n = cur;
        if (st.slave) begin
            n = MODE_LOCK;
        end else begin
            unique case (cur)
                MODE_FREE: if (st.ref_ok && st.locked) n = MODE_LOCK;
                MODE_LOCK: if (!st.ref_ok) n = hist_ok ? MODE_HOLD : MODE_FREE;
                MODE_HOLD: if (st.ref_ok && st.locked) n = MODE_LOCK;
                default:   n = MODE_FREE;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/tsrc_tick.sv
module tsrc_tick #(
    parameter int PERIOD = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    generate
        if (PERIOD <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_count
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst)               cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                   cnt_q <= cnt_q + 1'b1;
            end
            assign tick = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/tsrc_history.sv
module tsrc_history #(
    parameter int W         = 16,
    parameter int QUAL_N    = 16,
    parameter int AVG_SHIFT = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         in_lock_mode,
    input  logic         ref_ok,
    input  logic         locked,
    input  logic [W-1:0] sample,
    output logic [W-1:0] avg,
    output logic         avail
);
    localparam int QW = $clog2(QUAL_N + 1);
    localparam logic [QW-1:0] QMAX = QW'(QUAL_N);

    logic [QW-1:0] qcnt_q;
    logic [W-1:0]  avg_q;
    logic          upd, clr;
    logic signed [W:0] diff;
    logic signed [W:0] step;

    assign upd  = tick && in_lock_mode && ref_ok && locked;
    assign clr  = tick && in_lock_mode && !locked;
    assign diff = $signed({1'b0, sample}) - $signed({1'b0, avg_q});
    assign step = diff >>> AVG_SHIFT;

    always_ff @(posedge clk) begin
        if (rst) begin
            qcnt_q <= '0;
            avg_q  <= '0;
        end else if (clr) begin
            qcnt_q <= '0;
        end else if (upd) begin
            if (qcnt_q == '0) avg_q <= sample;
            else              avg_q <= avg_q + step[W-1:0];
            if (qcnt_q != QMAX) qcnt_q <= qcnt_q + 1'b1;
        end
    end

    assign avg   = avg_q;
    assign avail = (qcnt_q == QMAX);
endmodule

// File: rtl/tsrc_mode_fsm.sv
module tsrc_mode_fsm
    import tsrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tsrc_in_t   st,
    input  logic       hist_ok,
    output tsrc_mode_t mode,
    output logic       lol
);
    tsrc_mode_t mode_q;
    logic       lol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_FREE;
            lol_q  <= 1'b1;
        end else begin
            mode_q <= next_mode(mode_q, st, hist_ok);
            lol_q  <= !st.locked;
        end
    end

    assign mode = mode_q;
    assign lol  = lol_q;
endmodule

// File: rtl/tsrc_mode_ctrl.sv
module tsrc_mode_ctrl
    import tsrc_pkg::*;
#(
    parameter int          W          = 16,
    parameter int          UPD_PERIOD = 1000,
    parameter int          QUAL_N     = 16,
    parameter int          AVG_SHIFT  = 2,
    parameter logic [15:0] FREE_WORD  = 16'h8000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         slave_i,
    input  logic         ref_valid_i,
    input  logic         pll_lock_i,
    input  logic [W-1:0] ctrl_word_i,
    output logic [1:0]   mode_o,
    output logic         lol_o,
    output logic         hold_avail_o,
    output logic [W-1:0] freq_word_o
);
    localparam logic [W-1:0] FREE_W = W'(FREE_WORD);

    tsrc_in_t   st;
    tsrc_mode_t mode;
    logic       tick, hist_ok;
    logic [W-1:0] avg;

    assign st = '{slave: slave_i, ref_ok: ref_valid_i, locked: pll_lock_i};

    tsrc_tick #(.PERIOD(UPD_PERIOD)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    tsrc_history #(.W(W), .QUAL_N(QUAL_N), .AVG_SHIFT(AVG_SHIFT)) u_hist (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .in_lock_mode(mode == MODE_LOCK),
        .ref_ok      (ref_valid_i),
        .locked      (pll_lock_i),
        .sample      (ctrl_word_i),
        .avg         (avg),
        .avail       (hist_ok)
    );

    tsrc_mode_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .st     (st),
        .hist_ok(hist_ok),
        .mode   (mode),
        .lol    (lol_o)
    );

    always_comb begin
        unique case (mode)
            MODE_LOCK: freq_word_o = ctrl_word_i;
            MODE_HOLD: freq_word_o = avg;
            default:   freq_word_o = FREE_W;
        endcase
    end

    assign mode_o       = mode;
    assign hold_avail_o = hist_ok;
endmodule

// File: rtl/tsrc_mode_chk.sv
module tsrc_mode_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         slave_i,
    input logic         ref_valid_i,
    input logic         pll_lock_i,
    input logic [1:0]   mode_o,
    input logic         lol_o,
    input logic         hold_avail_o,
    input logic [W-1:0] freq_word_o
);
    AST_SLAVE_LOCKS: assert property (@(posedge clk) disable iff (rst)
        slave_i |=> (mode_o == 2'd1)); // R8
    AST_FREE_TO_LOCK: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0 && ref_valid_i && pll_lock_i) |=> (mode_o == 2'd1)); // R2
    AST_LOSS_TO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd1 && !slave_i && !ref_valid_i && hold_avail_o) |=> (mode_o == 2'd2)); // R5
    AST_LOSS_TO_FREE: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd1 && !slave_i && !ref_valid_i && !hold_avail_o) |=> (mode_o == 2'd0)); // R6
    AST_HOLD_RETURN: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2 && ref_valid_i && pll_lock_i) |=> (mode_o == 2'd1)); // R7
    AST_LOL_TRACK: assert property (@(posedge clk) disable iff (rst)
        pll_lock_i |=> !lol_o); // R9
    AST_HOLD_WORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2) |=> (mode_o != 2'd2 || $stable(freq_word_o))); // R10
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode_o != 2'd3); // R1
endmodule

bind tsrc_mode_ctrl tsrc_mode_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .slave_i     (slave_i),
    .ref_valid_i (ref_valid_i),
    .pll_lock_i  (pll_lock_i),
    .mode_o      (mode_o),
    .lol_o       (lol_o),
    .hold_avail_o(hold_avail_o),
    .freq_word_o (freq_word_o)
);

// File: tb/sim_tsrc_mode_ctrl.sv
module sim_tsrc_mode_ctrl;
    localparam int W   = 16;
    localparam int P   = 4;
    localparam int Q   = 16;
    localparam int SH  = 2;
    localparam logic [15:0] FW = 16'h8000;
    localparam logic [15:0] C1 = 16'h1234;
    localparam logic [15:0] C2 = 16'h2000;
    localparam logic [15:0] C3 = 16'h3000;

    // {slave, ref_valid, lock, expected mode[1:0], expected lol}
    localparam int NV = 9;
    localparam logic [5:0] VEC [NV] = '{
        6'b000_00_1, 6'b010_00_1, 6'b001_00_0, 6'b011_01_0, 6'b010_01_1,
        6'b000_00_1, 6'b100_01_1, 6'b101_01_0, 6'b001_00_0 };

    logic clk = 0, rst = 1, slave = 0, refv = 0, lock = 0;
    logic [W-1:0] ctrl = C1;
    logic [1:0] mode;
    logic lol, havail;
    logic [W-1:0] fword;
    int checks = 0, errors = 0, cyc = 0;
    logic [W-1:0] held;

    always #2.5 clk = ~clk;

    tsrc_mode_ctrl #(.W(W), .UPD_PERIOD(P), .QUAL_N(Q), .AVG_SHIFT(SH), .FREE_WORD(FW)) u0 (
        .clk(clk), .rst(rst), .slave_i(slave), .ref_valid_i(refv), .pll_lock_i(lock),
        .ctrl_word_i(ctrl), .mode_o(mode), .lol_o(lol), .hold_avail_o(havail),
        .freq_word_o(fword));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 0;
        step(1);
        chk("R1 mode", mode, 0);
        chk("R1 hold_avail", havail, 0);
        chk("R1 word", fword, FW);

        // table walk, one clock per vector
        for (int i = 0; i < NV; i++) begin
            {slave, refv, lock} = VEC[i][5:3];
            step(1);
            chk($sformatf("R2 R6 R8 vec%0d mode", i), mode, VEC[i][2:1]);
            chk($sformatf("R9 vec%0d lol", i), lol, VEC[i][0]);
            chk($sformatf("R3 vec%0d word", i), fword, (VEC[i][2:1] == 2'd1) ? ctrl : FW);
        end

        // fresh start, lock and qualify history
        rst = 1; slave = 0; refv = 0; lock = 0; ctrl = C1;
        step(2); rst = 0;
        refv = 1; lock = 1;
        step(1);
        chk("R2 lock", mode, 1);
        ctrl = C1 + 16'h11;
        #1 chk("R3 word follows ctrl", fword, C1 + 16'h11);
        ctrl = C1;
        step(15 * P);
        chk("R4 below threshold", havail, 0);
        step(2 * P);
        chk("R4 threshold reached", havail, 1);

        // a lock drop during an update clears the count
        lock = 0;
        step(P);
        chk("R4 cleared", havail, 0);
        chk("R9 lol high", lol, 1);
        lock = 1; ctrl = C2;
        step(17 * P);
        chk("R4 requalified", havail, 1);

        // average converges toward a new word
        ctrl = C3;
        step(40 * P);
        refv = 0;
        step(1);
        chk("R5 holdover", mode, 2);
        held = fword;
        checks++;
        if (!(held <= C3 && held >= C3 - 16'd3)) begin
            errors++;
            $display("FAIL R10 average actual=%h expected=%h..%h", held, C3 - 16'd3, C3);
        end
        ctrl = 16'h0F0F;
        step(3 * P);
        chk("R10 frozen word", fword, held);
        refv = 1; lock = 0;
        step(2);
        chk("R7 stays hold", mode, 2);
        lock = 1;
        step(1);
        chk("R7 back to lock", mode, 1);
        chk("R3 word live", fword, 16'h0F0F);

        // slave never enters holdover
        slave = 1; refv = 0;
        step(3);
        chk("R8 slave locked", mode, 1);
        slave = 0;
        step(1);
        chk("R5 master loss", mode, 2);
        chk("R10 hold word", fword, held);

        // lock lost without reference loss stays locked
        refv = 1; lock = 1;
        step(1);
        lock = 0;
        step(2);
        chk("R6 lock loss keeps mode", mode, 1);
        chk("R9 lol", lol, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule